// File: doc/BRIEF.md
# Register-Accessed CRC-16 Engine

This block computes a 16-bit cyclic redundancy check for the frames of a slow serial infrared link. Software drives it over a small 16-bit register bus. It writes a restart command, pushes the frame bytes one per write, and then reads back two things: how many items were absorbed, and the check value. A receiver compares that value with the trailing check of a frame. A transmitter appends it to a frame.

The polynomial is x^16 + x^12 + x^5 + 1, processed least significant bit first (the reflected constant 0x8408). The register is preset to all ones, and the value presented on the bus is the ones-complement of the register. Each byte is folded in during the clock edge that accepts the write, so the new result is readable in the very next cycle. A fixed four-byte self-test vector lets software confirm that the engine is healthy before it is used.

Top module: `crc16_reg_engine`

## Requirements
- R1: After reset is released, the control word (address 0) reads 0x0000 and the result word (address 2) reads 0x0000, since the internal register holds 0xFFFF.
- R2: A write to address 0 with bit 15 set restarts the engine: the item count returns to 0 and the internal register returns to 0xFFFF. Bit 15 does not stick and reads back as 0.
- R3: Reading address 0 gives the item count in bits 11:0, with bits 15:12 always 0.
- R4: Each write to address 1 absorbs bits 7:0 of the written word as one byte, least significant bit first, with the reflected polynomial 0x8408. Bits 15:8 of that word have no effect on the check value. Each such write adds one to the count.
- R5: Reading address 2 returns the ones-complement of the internal 16-bit register.
- R6: After a restart, writing 0xCC, 0xF5, 0xF1 and 0xA7 leaves a count of 4 and a result of 0x51DF.
- R7: A read in the cycle right after an input write already shows the updated count and result.
- R8: The 12-bit count wraps from 4095 to 0 on the next input write, and the check value keeps accumulating across the wrap.
- R9: Writes with the select low, writes to address 0 with bit 15 clear, and writes to address 2 or 3 leave both the count and the check value unchanged. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | Write qualifier; takes effect only with busSel high |
| busAddr | input | 2 | Word address: 0 control/count, 1 input, 2 result, 3 unused |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |

## Verification
The assertions watch three things on every cycle: a restart clears the count and the result, an input write steps the count by exactly one, and any other access leaves the count and the check value frozen. They also hold the upper control bits and the unused address at zero. Only the bench's scenarios can show that the check value is numerically right. Those scenarios cover the fixed self-test vector, byte streams compared against an independent bit-serial model, the fact that bits 15:8 of the input word are ignored, and the check value carrying on across the 4095-to-0 count wrap.

// File: rtl/crc16_reg_pkg.sv
`timescale 1ns/1ps
package crc16_reg_pkg;

  // Strobes from the bus decoder to the datapath, at most one per cycle
  typedef struct packed {
    logic restart;
    logic absorb;
  } crcStrobe_t;

endpackage

// File: rtl/crc16_reg_ctrl.sv
`timescale 1ns/1ps
module crc16_reg_ctrl
  import crc16_reg_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int COUNT_W     = 12,
  parameter int CRC_W       = 16,
  parameter int ADDR_CTRL   = 0,
  parameter int ADDR_INPUT  = 1,
  parameter int ADDR_RESULT = 2,
  parameter bit INVERT_OUT  = 1'b1
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CRC_W-1:0]  crcValue,
  input  logic [COUNT_W-1:0] itemCount,
  output crcStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata
);

  localparam int RESTART_BIT = DATA_W - 1;

  logic writeCycle;
  logic [CRC_W-1:0] resultWord;

  assign writeCycle = busSel && busWrite;

  always_comb begin
    strobe.restart = writeCycle && (busAddr == ADDR_W'(ADDR_CTRL)) && busWdata[RESTART_BIT];
    strobe.absorb  = writeCycle && (busAddr == ADDR_W'(ADDR_INPUT));
  end

  // Output polarity chosen by parameter
  generate
    if (INVERT_OUT) begin : g_inv
      assign resultWord = ~crcValue;
    end else begin : g_plain
      assign resultWord = crcValue;
    end
  endgenerate

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(ADDR_CTRL)) begin
      busRdata[COUNT_W-1:0] = itemCount;
    end else if (busAddr == ADDR_W'(ADDR_RESULT)) begin
      busRdata[CRC_W-1:0] = resultWord;
    end
  end

endmodule

// File: rtl/crc16_reg_datapath.sv
`timescale 1ns/1ps
module crc16_reg_datapath
  import crc16_reg_pkg::*;
#(
  parameter int CRC_W              = 16,
  parameter int BYTE_W             = 8,
  parameter int COUNT_W            = 12,
  parameter logic [CRC_W-1:0] POLY_REFL = 16'h8408,
  parameter logic [CRC_W-1:0] PRESET    = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  crcStrobe_t         strobe,
  input  logic [BYTE_W-1:0]  dataByte,
  output logic [CRC_W-1:0]   crcValue,
  output logic [COUNT_W-1:0] itemCount
);

  localparam int PAD_W = CRC_W - BYTE_W;

  logic [CRC_W-1:0] nextCrc;

  // Whole byte folded in one cycle: BYTE_W shift/xor steps unrolled
  always_comb begin
    logic [CRC_W-1:0] work;
    work = crcValue ^ {{PAD_W{1'b0}}, dataByte};
    for (int b = 0; b < BYTE_W; b++) begin
      if (work[0]) work = (work >> 1) ^ POLY_REFL;
      else         work = work >> 1;
    end
    nextCrc = work;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcValue  <= PRESET;
      itemCount <= '0;
    end else if (strobe.restart) begin
      crcValue  <= PRESET;
      itemCount <= '0;
    end else if (strobe.absorb) begin
      crcValue  <= nextCrc;
      itemCount <= itemCount + 1'b1;
    end
  end

endmodule

// File: rtl/crc16_reg_engine.sv
`timescale 1ns/1ps
module crc16_reg_engine
  import crc16_reg_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int COUNT_W     = 12,
  parameter int BYTE_W      = 8,
  parameter int ADDR_CTRL   = 0,
  parameter int ADDR_INPUT  = 1,
  parameter int ADDR_RESULT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);

  localparam int CRC_W = DATA_W;

  crcStrobe_t         strobe;
  logic [CRC_W-1:0]   crcValue;
  logic [COUNT_W-1:0] itemCount;

  crc16_reg_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .CRC_W(CRC_W),
    .ADDR_CTRL(ADDR_CTRL), .ADDR_INPUT(ADDR_INPUT), .ADDR_RESULT(ADDR_RESULT),
    .INVERT_OUT(1'b1)
  ) u_ctrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .crcValue(crcValue), .itemCount(itemCount),
    .strobe(strobe), .busRdata(busRdata)
  );

  crc16_reg_datapath #(
    .CRC_W(CRC_W), .BYTE_W(BYTE_W), .COUNT_W(COUNT_W),
    .POLY_REFL(16'h8408), .PRESET(16'hFFFF)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .dataByte(busWdata[BYTE_W-1:0]),
    .crcValue(crcValue), .itemCount(itemCount)
  );

endmodule

// File: rtl/crc16_reg_engine_checker.sv
`timescale 1ns/1ps
module crc16_reg_engine_checker #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int COUNT_W     = 12,
  parameter int ADDR_CTRL   = 0,
  parameter int ADDR_INPUT  = 1,
  parameter int ADDR_RESULT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busSel,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic [DATA_W-1:0]  crcValue,
  input logic [COUNT_W-1:0] itemCount
);

  logic wrRestart, wrInput;
  assign wrRestart = busSel && busWrite && (busAddr == ADDR_W'(ADDR_CTRL)) && busWdata[DATA_W-1];
  assign wrInput   = busSel && busWrite && (busAddr == ADDR_W'(ADDR_INPUT));

  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrRestart |=> (itemCount == '0) && (crcValue == '1));

  assert_restart_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrRestart |=> (busAddr != ADDR_W'(ADDR_RESULT)) || (busRdata == '0));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrInput |=> itemCount == $past(itemCount) + 1'b1);

  assert_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrInput && !wrRestart) |=> $stable(itemCount) && $stable(crcValue));

  assert_ctrl_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_W'(ADDR_CTRL)) |-> busRdata[DATA_W-1:COUNT_W] == '0);

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_W'(3)) |-> busRdata == '0);

endmodule

bind crc16_reg_engine crc16_reg_engine_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COUNT_W(COUNT_W),
  .ADDR_CTRL(ADDR_CTRL), .ADDR_INPUT(ADDR_INPUT), .ADDR_RESULT(ADDR_RESULT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .crcValue(crcValue), .itemCount(itemCount)
);

// File: tb/crc16_reg_engine_bench.sv
`timescale 1ns/1ps
module crc16_reg_engine_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] modelCrc = 16'hFFFF;
  logic [11:0] modelCount = 12'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_reg_engine u_crc16_reg_engine (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  // Bit-serial reference: reflected polynomial, LSB first
  function automatic logic [15:0] refStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic checkEq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [15:0] d, input bit sel = 1'b1);
    @(negedge clk);
    busSel = sel; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic pushByte(input logic [15:0] w);
    busWr(2'd1, w);
    modelCrc = refStep(modelCrc, w[7:0]);
    modelCount = modelCount + 1'b1;
  endtask

  task automatic restart();
    busWr(2'd0, 16'h8000);
    modelCrc = 16'hFFFF;
    modelCount = 12'd0;
  endtask

  task automatic checkState(input string tag);
    logic [15:0] v;
    busRd(2'd0, v); checkEq({tag, " count"}, v, {4'h0, modelCount});
    busRd(2'd2, v); checkEq({tag, " result"}, v, ~modelCrc);
  endtask

  task automatic testReset();
    logic [15:0] v;
    busRd(2'd0, v); checkEq("R1 ctrl after reset", v, 16'h0000);
    busRd(2'd2, v); checkEq("R1 result after reset", v, 16'h0000);
  endtask

  task automatic testCheckVector();
    logic [15:0] v;
    restart();
    pushByte(16'h00CC); pushByte(16'h00F5); pushByte(16'h00F1); pushByte(16'h00A7);
    busRd(2'd0, v); checkEq("R6 count", v, 16'd4);
    busRd(2'd2, v); checkEq("R6 result", v, 16'h51DF);
  endtask

  task automatic testPatterns();
    restart();
    for (int i = 0; i < 20; i++) pushByte(16'((i * 37 + 5) & 8'hFF));
    checkState("R4 ramp pattern");
    restart();
    pushByte(16'h0000); pushByte(16'h00FF); pushByte(16'h0055); pushByte(16'h00AA);
    checkState("R4 edge bytes");
    checkState("R5 complement");
  endtask

  task automatic testUpperIgnored();
    logic [15:0] a, b;
    restart();
    pushByte(16'h0012); pushByte(16'h0034);
    busRd(2'd2, a);
    restart();
    pushByte(16'hAB12); pushByte(16'hFF34);
    busRd(2'd2, b);
    checkEq("R4 upper bits ignored", b, a);
    checkState("R4 upper bits count");
  endtask

  task automatic testRestart();
    logic [15:0] v;
    restart();
    pushByte(16'h0077); pushByte(16'h0011);
    busWr(2'd0, 16'hFFFF);
    modelCrc = 16'hFFFF; modelCount = 12'd0;
    busRd(2'd0, v); checkEq("R2 restart count and bit15 reads 0", v, 16'h0000);
    busRd(2'd2, v); checkEq("R2 restart result", v, 16'h0000);
    busRd(2'd0, v); checkEq("R3 upper control bits", v & 16'hF000, 16'h0000);
  endtask

  task automatic testNextCycle();
    logic [15:0] v;
    restart();
    pushByte(16'h0042);
    busRd(2'd2, v); checkEq("R7 next-cycle result", v, ~modelCrc);
    pushByte(16'h0099);
    busRd(2'd0, v); checkEq("R7 next-cycle count", v, {4'h0, modelCount});
  endtask

  task automatic testIgnored();
    logic [15:0] v;
    restart();
    pushByte(16'h003C);
    busWr(2'd1, 16'h00E1, 1'b0);
    checkState("R9 select low");
    busWr(2'd0, 16'h7FFF);
    checkState("R9 ctrl bit15 clear");
    busWr(2'd2, 16'h1234);
    checkState("R9 result write");
    busWr(2'd3, 16'h8000);
    checkState("R9 unused write");
    busRd(2'd3, v); checkEq("R9 unused reads 0", v, 16'h0000);
  endtask

  task automatic testWrap();
    logic [15:0] v;
    restart();
    for (int i = 0; i < 4095; i++) pushByte(16'(i & 8'hFF));
    busRd(2'd0, v); checkEq("R8 count 4095", v, 16'd4095);
    pushByte(16'h005A);
    busRd(2'd0, v); checkEq("R8 count wrapped", v, 16'd0);
    pushByte(16'h00C3);
    checkState("R8 after wrap");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testCheckVector();
    testPatterns();
    testUpperIgnored();
    testRestart();
    testNextCycle();
    testIgnored();
    testWrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule